// File: doc/BRIEF.md
# Vectored Interrupt Entry Controller

This block stands between a set of interrupt request sources and the sequencer of a small CPU. It records requests from eight hardware lines and from software, and it picks one of them at a time. It then waits for the sequencer to report that the current instruction is complete. At that boundary it stops the CPU, places the handler address on a program-counter load bus, strobes the load, and lets the CPU run again from the handler. Return from the handler and saving of context are handled elsewhere.

Each hardware line has a handler address taken from static configuration inputs. A software request carries an 8-bit number. Numbers below eight reuse the hardware entries. Any other number selects an address built from a fixed page byte followed by the number. One enable input gates the whole controller.

Top module: `irq_vec_ctrl`

## Requirements
- R1: A request pulse of one cycle on any of the eight hardware lines is held as pending and is serviced later, even after the line has returned low.
- R2: When several requests are pending, the hardware line with the lowest index is served first, and any pending hardware line is served before a pending software request.
- R3: Hardware line k loads the vector `hw_vec_i[16k+15:16k]`. `pc_vec_o` holds that value unchanged for as long as `halt_o` is high.
- R4: A software number n in 0..7 loads the vector of hardware line n. Any other n loads `{SW_PAGE, n}`, where `SW_PAGE` defaults to 8'hFE.
- R5: Once a request is selected, the controller waits for `insn_done_i`. `halt_o` rises in the cycle after the first clock edge at which `insn_done_i` is sampled high.
- R6: Each service keeps `halt_o` high for exactly two cycles. `pc_load_o` is high for exactly one cycle, the second of those two, with the vector on `pc_vec_o`. `halt_o` drops in the cycle that follows.
- R7: While `irq_en_i` is low, new hardware and software requests are not recorded and no service starts.
- R8: A request is cleared when its service completes, so it is serviced exactly once.
- R9: No new selection is made while a service is in progress, even for a lower-indexed line. Hardware requests that arrive during that time are kept and served afterwards.
- R10: A software request that arrives while an earlier software request is still pending is dropped. The earlier request keeps its number.
- R11: After reset `halt_o` and `pc_load_o` are low and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_en_i | input | 1 | Global interrupt enable |
| hw_req_i | input | 8 | Hardware request lines, one per device |
| sw_req_i | input | 1 | Software interrupt request strobe |
| sw_num_i | input | 8 | Software interrupt number, sampled with sw_req_i |
| insn_done_i | input | 1 | Current instruction has finished |
| hw_vec_i | input | 128 | Static handler addresses, 16 bits per hardware line, line 0 in the low bits |
| halt_o | output | 1 | Stop the CPU sequencer |
| pc_load_o | output | 1 | One-cycle program counter load strobe |
| pc_vec_o | output | 16 | Handler address to load |

## Verification
The assertions check the following on every cycle:
- the handshake shape: halt rises only after a boundary, the load follows one cycle into halt and lasts one cycle, and halt releases right after the load;
- the vector stays stable during halt;
- no service starts while the controller is disabled.

Only the bench scenarios can show which vector was chosen, and in what order:
- the sweeps over the hardware lines and over every software number;
- a simultaneous burst that tests priority;
- a late lower-indexed request that tests non-preemption;
- checks that dropped or gated requests never produce a load.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HALT,
    ST_LOAD,
    ST_RELEASE
  } seq_state_e;
endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int unsigned NUM_HW = 8,
  parameter int unsigned NUM_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [NUM_HW-1:0] hw_req_i,
  input  logic [NUM_HW-1:0] hw_clr_i,
  input  logic              sw_req_i,
  input  logic [NUM_W-1:0]  sw_num_i,
  input  logic              sw_clr_i,
  output logic [NUM_HW-1:0] hw_pend_o,
  output logic              sw_pend_o,
  output logic [NUM_W-1:0]  sw_num_o
);
  logic [NUM_HW-1:0] hw_pend_q;
  logic              sw_v_q;
  logic [NUM_W-1:0]  sw_num_q;

  // set wins over clear so a fresh pulse during completion is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hw_pend_q <= '0;
    else         hw_pend_q <= (hw_pend_q & ~hw_clr_i) | (hw_req_i & {NUM_HW{en_i}});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_v_q   <= 1'b0;
      sw_num_q <= '0;
    end else if (sw_req_i && en_i && (!sw_v_q || sw_clr_i)) begin
      sw_v_q   <= 1'b1;
      sw_num_q <= sw_num_i;
    end else if (sw_clr_i) begin
      sw_v_q   <= 1'b0;
    end
  end

  assign hw_pend_o = hw_pend_q;
  assign sw_pend_o = sw_v_q;
  assign sw_num_o  = sw_num_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned NUM_HW = 8,
  localparam int unsigned IDX_W = (NUM_HW > 1) ? $clog2(NUM_HW) : 1
) (
  input  logic [NUM_HW-1:0] pend_i,
  output logic              any_o,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_HW - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |pend_i;
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_vec_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic insn_done_i,
  output logic accept_o,
  output logic halt_o,
  output logic load_o,
  output logic done_o,
  output logic busy_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_WAIT;
      ST_WAIT:    if (insn_done_i) state_d = ST_HALT;
      ST_HALT:    state_d = ST_LOAD;
      ST_LOAD:    state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign halt_o   = (state_q == ST_HALT) || (state_q == ST_LOAD);
  assign load_o   = (state_q == ST_LOAD);
  assign done_o   = (state_q == ST_RELEASE);
  assign busy_o   = (state_q != ST_IDLE);
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int unsigned NUM_HW  = 8,
  parameter int unsigned VEC_W   = 16,
  parameter int unsigned NUM_W   = 8,
  parameter logic [VEC_W-NUM_W-1:0] SW_PAGE = 'hFE
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    irq_en_i,
  input  logic [NUM_HW-1:0]       hw_req_i,
  input  logic                    sw_req_i,
  input  logic [NUM_W-1:0]        sw_num_i,
  input  logic                    insn_done_i,
  input  logic [NUM_HW*VEC_W-1:0] hw_vec_i,
  output logic                    halt_o,
  output logic                    pc_load_o,
  output logic [VEC_W-1:0]        pc_vec_o
);
  localparam int unsigned IDX_W = (NUM_HW > 1) ? $clog2(NUM_HW) : 1;
  localparam logic [NUM_W-1:0] HW_LIM = NUM_W'(NUM_HW);

  logic [VEC_W-1:0]  hw_vec_a [NUM_HW];
  logic [NUM_HW-1:0] hw_pend, hw_clr;
  logic              sw_pend, sw_clr;
  logic [NUM_W-1:0]  sw_num;
  logic              hw_any;
  logic [IDX_W-1:0]  hw_idx;
  logic              start, accept, done, busy;
  logic [VEC_W-1:0]  sw_vec, sel_vec;
  logic              src_hw_q;
  logic [IDX_W-1:0]  src_idx_q;
  logic [VEC_W-1:0]  vec_q;

  for (genvar g = 0; g < NUM_HW; g++) begin : g_vec
    assign hw_vec_a[g] = hw_vec_i[g*VEC_W +: VEC_W];
  end

  irq_pend_latch #(.NUM_HW(NUM_HW), .NUM_W(NUM_W)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (irq_en_i),
    .hw_req_i  (hw_req_i),
    .hw_clr_i  (hw_clr),
    .sw_req_i  (sw_req_i),
    .sw_num_i  (sw_num_i),
    .sw_clr_i  (sw_clr),
    .hw_pend_o (hw_pend),
    .sw_pend_o (sw_pend),
    .sw_num_o  (sw_num)
  );

  irq_prio_pick #(.NUM_HW(NUM_HW)) u_pick (
    .pend_i (hw_pend),
    .any_o  (hw_any),
    .idx_o  (hw_idx)
  );

  assign start = irq_en_i && (hw_any || sw_pend);

  irq_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .insn_done_i (insn_done_i),
    .accept_o    (accept),
    .halt_o      (halt_o),
    .load_o      (pc_load_o),
    .done_o      (done),
    .busy_o      (busy)
  );

  // low software numbers alias the hardware entries
  always_comb begin
    if (sw_num < HW_LIM) sw_vec = hw_vec_a[sw_num[IDX_W-1:0]];
    else                 sw_vec = {SW_PAGE, sw_num};
  end

  assign sel_vec = hw_any ? hw_vec_a[hw_idx] : sw_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_hw_q  <= 1'b0;
      src_idx_q <= '0;
      vec_q     <= '0;
    end else if (accept) begin
      src_hw_q  <= hw_any;
      src_idx_q <= hw_idx;
      vec_q     <= sel_vec;
    end
  end

  assign hw_clr   = (done && src_hw_q) ? (NUM_HW'(1) << src_idx_q) : '0;
  assign sw_clr   = done && !src_hw_q;
  assign pc_vec_o = vec_q;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int unsigned VEC_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_en_i,
  input logic             insn_done_i,
  input logic             halt_i,
  input logic             pc_load_i,
  input logic [VEC_W-1:0] pc_vec_i,
  input logic             busy_i
);
  AST_LOAD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_i |=> !pc_load_i); // R6
  AST_LOAD_IN_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_i |-> halt_i); // R6
  AST_HALT_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_i) |-> $past(insn_done_i)); // R5
  AST_HALT_THEN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_i) |=> pc_load_i); // R6
  AST_RELEASE_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_i |=> !halt_i); // R6
  AST_VEC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && $past(halt_i)) |-> $stable(pc_vec_i)); // R3
  AST_DISABLED_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !irq_en_i) |=> !busy_i); // R7
  AST_HALT_IN_SERVICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |-> busy_i); // R9
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_en_i    (irq_en_i),
  .insn_done_i (insn_done_i),
  .halt_i      (halt_o),
  .pc_load_i   (pc_load_o),
  .pc_vec_i    (pc_vec_o),
  .busy_i      (busy)
);

// File: tb/irq_vec_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         irq_en_i = 1'b1;
  logic [7:0]   hw_req_i = '0;
  logic         sw_req_i = 1'b0;
  logic [7:0]   sw_num_i = '0;
  logic         insn_done_i = 1'b1;
  logic [127:0] hw_vec_i;
  logic         halt_o, pc_load_o;
  logic [15:0]  pc_vec_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] log_vec [512];
  int log_cnt = 0;

  always #2.5 clk_i = ~clk_i;

  irq_vec_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_en_i(irq_en_i), .hw_req_i(hw_req_i),
    .sw_req_i(sw_req_i), .sw_num_i(sw_num_i), .insn_done_i(insn_done_i),
    .hw_vec_i(hw_vec_i), .halt_o(halt_o), .pc_load_o(pc_load_o), .pc_vec_o(pc_vec_o)
  );

  function automatic logic [15:0] hv(int k);
    return 16'h1000 + 16'(k) * 16'h0111;
  endfunction

  function automatic logic [15:0] swv(int n);
    return (n < 8) ? hv(n) : {8'hFE, 8'(n)};
  endfunction

  always_comb
    for (int k = 0; k < 8; k++) hw_vec_i[k*16 +: 16] = hv(k);

  always @(negedge clk_i)
    if (rst_ni && pc_load_o) begin
      if (log_cnt < 512) log_vec[log_cnt] = pc_vec_o;
      log_cnt++;
    end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_hw(logic [7:0] m);
    @(negedge clk_i); hw_req_i = m;
    @(negedge clk_i); hw_req_i = '0;
  endtask

  task automatic pulse_sw(int n);
    @(negedge clk_i); sw_req_i = 1'b1; sw_num_i = 8'(n);
    @(negedge clk_i); sw_req_i = 1'b0;
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    int base;
    cyc(3);
    rst_ni = 1'b1;
    // R11 reset state
    chk(halt_o == 1'b0 && pc_load_o == 1'b0, "R11", {halt_o, pc_load_o}, 0);
    cyc(10);
    chk(log_cnt == 0, "R11", log_cnt, 0);

    // R1 R3: single-cycle pulse on each line
    for (int k = 0; k < 8; k++) begin
      base = log_cnt;
      pulse_hw(8'(1 << k));
      cyc(10);
      chk(log_cnt == base + 1, "R1", log_cnt - base, 1);
      chk(log_vec[base] == hv(k), "R3", log_vec[base], hv(k));
    end

    // R2 R8: all lines at once, lowest first, each once
    base = log_cnt;
    pulse_hw(8'hFF);
    cyc(80);
    chk(log_cnt == base + 8, "R8", log_cnt - base, 8);
    for (int k = 0; k < 8; k++)
      chk(log_vec[base + k] == hv(k), "R2", log_vec[base + k], hv(k));

    // R4: every software number
    for (int n = 0; n < 256; n++) begin
      base = log_cnt;
      pulse_sw(n);
      cyc(8);
      chk(log_cnt == base + 1 && log_vec[base] == swv(n), "R4", log_vec[base], swv(n));
    end

    // R2: hardware before software when raised together
    base = log_cnt;
    @(negedge clk_i); hw_req_i = 8'h08; sw_req_i = 1'b1; sw_num_i = 8'h40;
    @(negedge clk_i); hw_req_i = '0; sw_req_i = 1'b0;
    cyc(20);
    chk(log_cnt == base + 2, "R2", log_cnt - base, 2);
    chk(log_vec[base] == hv(3), "R2", log_vec[base], hv(3));
    chk(log_vec[base + 1] == 16'hFE40, "R2", log_vec[base + 1], 16'hFE40);

    // R5 R6: exact handshake timing at the boundary
    insn_done_i = 1'b0;
    base = log_cnt;
    pulse_hw(8'h04);
    cyc(20);
    chk(halt_o == 1'b0 && log_cnt == base, "R5", halt_o, 0);
    insn_done_i = 1'b1;
    cyc(1);
    chk(halt_o == 1'b1 && pc_load_o == 1'b0, "R5", {halt_o, pc_load_o}, 2);
    cyc(1);
    chk(halt_o == 1'b1 && pc_load_o == 1'b1, "R6", {halt_o, pc_load_o}, 3);
    chk(pc_vec_o == hv(2), "R6", pc_vec_o, hv(2));
    cyc(1);
    chk(halt_o == 1'b0 && pc_load_o == 1'b0, "R6", {halt_o, pc_load_o}, 0);
    cyc(5);

    // R9: lower line arriving mid-service waits its turn
    insn_done_i = 1'b0;
    base = log_cnt;
    pulse_hw(8'h20);
    cyc(3);
    pulse_hw(8'h02);
    cyc(3);
    insn_done_i = 1'b1;
    cyc(20);
    chk(log_cnt == base + 2, "R9", log_cnt - base, 2);
    chk(log_vec[base] == hv(5), "R9", log_vec[base], hv(5));
    chk(log_vec[base + 1] == hv(1), "R9", log_vec[base + 1], hv(1));

    // R7: disabled requests are not recorded
    base = log_cnt;
    irq_en_i = 1'b0;
    @(negedge clk_i); hw_req_i = 8'h10; sw_req_i = 1'b1; sw_num_i = 8'h09;
    @(negedge clk_i); hw_req_i = '0; sw_req_i = 1'b0;
    cyc(20);
    chk(log_cnt == base && halt_o == 1'b0, "R7", log_cnt - base, 0);
    irq_en_i = 1'b1;
    cyc(20);
    chk(log_cnt == base, "R7", log_cnt - base, 0);

    // R10: second software request while first pending is dropped
    insn_done_i = 1'b0;
    base = log_cnt;
    pulse_sw(8'h21);
    cyc(3);
    pulse_sw(8'h33);
    cyc(3);
    insn_done_i = 1'b1;
    cyc(20);
    chk(log_cnt == base + 1, "R10", log_cnt - base, 1);
    chk(log_vec[base] == 16'hFE21, "R10", log_vec[base], 16'hFE21);

    report();
  end
endmodule